// File: doc/BRIEF.md
# NAND Controller Interrupt Status Unit

This unit sits beside a NAND flash controller core and turns six event signals from that core into interrupt state. The six sources are NAND ready, controller ready, decode failure, decode error, ECC ready and write-protect fault. A rising edge on any source latches a sticky flag. The flags pass through a mask register and drive one level-high interrupt line. Software reads the sticky register to learn which events occurred, and that read also clears them.

Next to the sticky view there is a raw status register. Each cycle it takes a snapshot of the core's live conditions: NAND ready, controller ready, ECC ready, errors detected, a 2-bit corrected-error count and decoder failure. Reading it clears nothing. A device-ready output gives the combined readiness that software otherwise builds from two raw bits.

Access is through a simple register port: a select, a read strobe, a write strobe and write data. Read data is registered and holds until the next read.

Top module: `nand_irq_status_unit`

## Requirements
- R1: The sticky register (select 0) holds one flag per source: bit 5 NAND ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault. `evt_i` uses the same positions. A 0-to-1 change on an `evt_i` bit sets its flag, which is visible in the cycle after the edge.
- R2: A read strobe with select 0 places the flags in `reg_rdata` in the next cycle, with bits 7:6 zero. It also clears every flag.
- R3: An event edge that arrives in the same cycle as a clearing read leaves its flag set after the read.
- R4: An `evt_i` bit that stays high sets its flag only once. After a clearing read the flag stays clear until the input falls and rises again.
- R5: A write with select 1 loads `reg_wdata[5:0]` into the mask, and a read with select 1 returns it. `irq_o` is high exactly while some flag is set whose mask bit is also set.
- R6: The raw register (select 2) is a one-cycle-delayed snapshot of the live inputs. Its layout is: bit 0 NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits 5:4 count, bit 6 decoder failure, bit 7 zero. Reading it changes no state.
- R7: The count field holds the number of corrected errors minus one, so 0 means one error and 3 means four. It reads 0 whenever errors-detected is clear.
- R8: `dev_ready_o` is high exactly when raw bit 0 and raw bit 1 are both set.
- R9: After reset all flags and mask bits are zero, `irq_o` is low and `reg_rdata` is zero.
- R10: Writes with select 0, 2 or 3 change no state. A read with select 3 returns zero. `reg_rdata` holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event sources, rising-edge detected |
| live_nand_rdy_i | input | 1 | Live NAND ready |
| live_ctrl_rdy_i | input | 1 | Live controller ready |
| live_ecc_rdy_i | input | 1 | Live ECC ready |
| live_err_det_i | input | 1 | Live errors detected |
| live_err_cnt_i | input | 2 | Corrected errors minus one |
| live_dec_fail_i | input | 1 | Live decoder failure |
| reg_sel_i | input | 2 | Register select: 0 sticky, 1 mask, 2 raw, 3 none |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| dev_ready_o | output | 1 | NAND ready and controller ready |

## Verification
The bench aims at these corner cases:

- An event edge that coincides with a clearing read. A design that clears first would drop that event.
- Sources held high across a clear. A design that detects levels instead of edges would set the flag again right away.
- Masked flags. If the gating were wrong, the interrupt would fire on them or fail to drop after a clear.
- The count field with errors-detected low, and stray writes to read-only selects. A design that got either wrong would show a stale count or a corrupted mask.

// File: rtl/nisu_pkg.sv
package nisu_pkg;
  localparam int unsigned EVT_W  = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned CNT_W  = 2;
  localparam int unsigned RAW_W  = 4 + CNT_W + 1;

  localparam logic [SEL_W-1:0] SEL_STICKY = 2'd0;
  localparam logic [SEL_W-1:0] SEL_MASK   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RAW    = 2'd2;

  // raw snapshot field positions
  localparam int unsigned RAW_NAND = 0;
  localparam int unsigned RAW_CTRL = 1;
  localparam int unsigned RAW_ECC  = 2;
  localparam int unsigned RAW_DET  = 3;
  localparam int unsigned RAW_CNT  = 4;
  localparam int unsigned RAW_FAIL = RAW_CNT + CNT_W;

  typedef struct packed {
    logic             nand_rdy;
    logic             ctrl_rdy;
    logic             ecc_rdy;
    logic             err_det;
    logic [CNT_W-1:0] err_cnt;
    logic             dec_fail;
  } live_t;
endpackage

// File: rtl/nisu_evt_latch.sv
module nisu_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic evt_q, evt_d;
  logic flag_q, flag_d;
  logic rise;

  always_comb begin
    rise   = evt_i & ~evt_q;
    evt_d  = evt_i;
    flag_d = (flag_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !evt_q) |=> flag_q); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(evt_i && !evt_q)) |=> !flag_q); // R2
  AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && evt_q && !flag_q) |=> !flag_q); // R4
endmodule

// File: rtl/nisu_mask_gate.sv
module nisu_mask_gate
  import nisu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [EVT_W-1:0] wdata_i,
  input  logic [EVT_W-1:0] flags_i,
  output logic [EVT_W-1:0] mask_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(flags_i & mask_q);

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q)); // R10
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones(mask_q) > 0)); // R5
endmodule

// File: rtl/nisu_raw_snap.sv
module nisu_raw_snap
  import nisu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  live_t            live_i,
  output logic [RAW_W-1:0] raw_o
);
  logic [RAW_W-1:0] raw_q, raw_d;

  always_comb begin
    raw_d                      = '0;
    raw_d[RAW_NAND]            = live_i.nand_rdy;
    raw_d[RAW_CTRL]            = live_i.ctrl_rdy;
    raw_d[RAW_ECC]             = live_i.ecc_rdy;
    raw_d[RAW_DET]             = live_i.err_det;
    raw_d[RAW_CNT +: CNT_W]    = live_i.err_det ? live_i.err_cnt : '0;
    raw_d[RAW_FAIL]            = live_i.dec_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  AST_CNT_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_q[RAW_DET] |-> (raw_q[RAW_CNT +: CNT_W] == '0)); // R7
endmodule

// File: rtl/nand_irq_status_unit.sv
module nand_irq_status_unit
  import nisu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              live_nand_rdy_i,
  input  logic              live_ctrl_rdy_i,
  input  logic              live_ecc_rdy_i,
  input  logic              live_err_det_i,
  input  logic [CNT_W-1:0]  live_err_cnt_i,
  input  logic              live_dec_fail_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              dev_ready_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             clr_sticky;
  logic             mask_we;
  logic [EVT_W-1:0] flags;
  logic [EVT_W-1:0] mask;
  logic [RAW_W-1:0] raw;
  live_t            live;

  assign clr_sticky = reg_rd_i && (reg_sel_i == SEL_STICKY);
  assign mask_we    = reg_wr_i && (reg_sel_i == SEL_MASK);

  for (genvar g = 0; g < EVT_W; g++) begin : g_evt
    nisu_evt_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .evt_i  (evt_i[g]),
      .clr_i  (clr_sticky),
      .flag_o (flags[g])
    );
  end

  nisu_mask_gate u_mask (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i[EVT_W-1:0]),
    .flags_i (flags),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  always_comb begin
    live.nand_rdy = live_nand_rdy_i;
    live.ctrl_rdy = live_ctrl_rdy_i;
    live.ecc_rdy  = live_ecc_rdy_i;
    live.err_det  = live_err_det_i;
    live.err_cnt  = live_err_cnt_i;
    live.dec_fail = live_dec_fail_i;
  end

  nisu_raw_snap u_raw (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .live_i (live),
    .raw_o  (raw)
  );

  assign dev_ready_o = raw[RAW_NAND] & raw[RAW_CTRL];

  // read data register
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;

  always_comb begin
    rd_mux = '0;
    case (reg_sel_i)
      SEL_STICKY: rd_mux[EVT_W-1:0] = flags;
      SEL_MASK:   rd_mux[EVT_W-1:0] = mask;
      SEL_RAW:    rd_mux[RAW_W-1:0] = raw;
      default:    rd_mux = '0;
    endcase
    rdata_d = reg_rd_i ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign reg_rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R10
  AST_STICKY_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr_sticky |=> (reg_rdata_o[DATA_W-1:EVT_W] == '0)); // R2
  AST_READY_BITS: assert property (@(posedge clk) disable iff (!rst_int_n)
    dev_ready_o |-> (raw[RAW_NAND] && raw[RAW_CTRL])); // R8
endmodule

// File: tb/test_nand_irq_status_unit.sv
`timescale 1ns/1ps
module test_nand_irq_status_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] evt;
  logic       l_nand, l_ctrl, l_ecc, l_det, l_fail;
  logic [1:0] l_cnt;
  logic [1:0] sel;
  logic       rd, wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq, rdy;

  always #5 clk = ~clk;

  nand_irq_status_unit i_nand_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .live_nand_rdy_i(l_nand), .live_ctrl_rdy_i(l_ctrl), .live_ecc_rdy_i(l_ecc),
    .live_err_det_i(l_det), .live_err_cnt_i(l_cnt), .live_dec_fail_i(l_fail),
    .reg_sel_i(sel), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .dev_ready_o(rdy)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench model
  logic [5:0] m_flags, m_mask, m_prev;
  logic [7:0] m_raw, m_rdata;

  function automatic logic [7:0] f_raw(input logic n, c, e, d, input logic [1:0] k, input logic f);
    return {1'b0, f, (d ? k : 2'b00), d, e, c, n};
  endfunction

  function automatic logic [7:0] f_read(input logic [1:0] s, input logic [5:0] fl,
                                        input logic [5:0] mk, input logic [7:0] rw);
    case (s)
      2'd0: return {2'b00, fl};
      2'd1: return {2'b00, mk};
      2'd2: return rw;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " rdata R2 R6 R10"}, rdata, m_rdata);
    check({req, " irq R5"}, {7'd0, irq}, {7'd0, |(m_flags & m_mask)});
    check({req, " ready R8"}, {7'd0, rdy}, {7'd0, m_raw[0] & m_raw[1]});
  endtask

  // drive at negedge (after checks), advance model, wait to next negedge
  task automatic step(input logic [5:0] e, input logic [1:0] s, input logic r, input logic w,
                      input logic [7:0] wd, input logic n, c, ec, d, input logic [1:0] k,
                      input logic f, input string req);
    logic [5:0] rise;
    evt = e; sel = s; rd = r; wr = w; wdata = wd;
    l_nand = n; l_ctrl = c; l_ecc = ec; l_det = d; l_cnt = k; l_fail = f;
    rise = e & ~m_prev;
    if (r) m_rdata = f_read(s, m_flags, m_mask, m_raw);
    m_flags = ((r && s == 2'd0) ? 6'd0 : m_flags) | rise;
    if (w && s == 2'd1) m_mask = wd[5:0];
    m_raw = f_raw(n, c, ec, d, k, f);
    m_prev = e;
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic idle(input string req);
    step(m_prev, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; evt = '0; sel = '0; rd = 0; wr = 0; wdata = '0;
    l_nand = 0; l_ctrl = 0; l_ecc = 0; l_det = 0; l_cnt = 0; l_fail = 0;
    m_flags = '0; m_mask = '0; m_prev = '0; m_raw = '0; m_rdata = '0;
    repeat (3) @(negedge clk);
    check_outputs("R9 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outputs("R9 after reset");
    // R9: mask and sticky read zero
    step('0, 2'd1, 1, 0, 8'h00, 0,0,0,0,2'd0,0, "R9 mask read");
    check("R9 mask zero", rdata, 8'h00);
    step('0, 2'd0, 1, 0, 8'h00, 0,0,0,0,2'd0,0, "R9 sticky read");

    // R1/R5: single event at bit 5, unmasked -> no irq; then mask it
    step(6'b100000, 2'd0, 0, 0, 8'h00, 0,0,0,0,2'd0,0, "R1 evt");
    check("R5 masked off irq low", {7'd0, irq}, 8'd0);
    step(6'b100000, 2'd1, 0, 1, 8'hE0, 0,0,0,0,2'd0,0, "R5 mask wr");
    check("R5 irq raised", {7'd0, irq}, 8'd1);
    // R2: clearing read
    step(6'b100000, 2'd0, 1, 0, 8'h00, 0,0,0,0,2'd0,0, "R2 clear");
    check("R2 sticky value", rdata, 8'h20);
    check("R4 irq low after clear with held level", {7'd0, irq}, 8'd0);
    idle("R4 held");
    check("R4 no re-set on held level", {7'd0, irq}, 8'd0);

    // R3: edge coincident with clearing read
    step(6'b100001, 2'd0, 0, 0, 8'h00, 0,0,0,0,2'd0,0, "R3 prep");
    step(6'b100011, 2'd0, 1, 0, 8'h00, 0,0,0,0,2'd0,0, "R3 same-cycle");
    check("R3 read shows old flag", rdata, 8'h01);
    step(6'b100011, 2'd0, 1, 0, 8'h00, 0,0,0,0,2'd0,0, "R3 reread");
    check("R3 flag survived", rdata, 8'h02);

    // R10: writes to selects 0,2,3 ignored; select 3 reads zero
    step('0, 2'd0, 0, 1, 8'hFF, 0,0,0,0,2'd0,0, "R10 wr sticky");
    step('0, 2'd2, 0, 1, 8'h00, 0,0,0,0,2'd0,0, "R10 wr raw");
    step('0, 2'd3, 1, 1, 8'h00, 0,0,0,0,2'd0,0, "R10 sel3");
    check("R10 sel3 zero", rdata, 8'h00);
    step('0, 2'd1, 1, 0, 8'h00, 0,0,0,0,2'd0,0, "R10 mask kept");
    check("R10 mask unchanged", rdata, 8'h20);

    // R6/R7/R8: raw layout and count
    step('0, 2'd0, 0, 0, 8'h00, 1,1,1,1,2'd3,1, "R6 load");
    step('0, 2'd2, 1, 0, 8'h00, 1,1,1,1,2'd3,1, "R6 read");
    check("R6 raw all set, count 3 means four errors (R7)", rdata, 8'h7F);
    step('0, 2'd2, 1, 0, 8'h00, 1,0,0,0,2'd3,0, "R7 det low");
    step('0, 2'd2, 1, 0, 8'h00, 1,0,0,0,2'd3,0, "R7 read");
    check("R7 count hidden", rdata, 8'h01);
    check("R8 not ready", {7'd0, rdy}, 8'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] e;
      logic [31:0] r;
      r = $urandom;
      e = m_prev ^ ((r[2:0] == 3'd0) ? 6'($urandom) : 6'd0);
      step(e, 2'(r[5:4]), r[8:6] == 3'd0, r[11:9] == 3'd0, 8'($urandom),
           r[12], r[13], r[14], r[15], 2'(r[17:16]), r[18], "R1 R5 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule